// File: doc/BRIEF.md
# Dual Clock Source Selection Guard

This block sits between software and a pair of clock generators, referred to here as source 0 and source 1. Software uses a single write port to set a 5-bit multiplier code and a 2-bit range for each source, an off bit for source 0, and a select bit. The select bit picks which source drives the core clock. Every write is checked against a set of legality rules before any state changes. An accepted write updates the registers. A rejected write changes nothing, and it raises a sticky error flag with a cause code.

Each source has a lock model: a down-counter that is reloaded whenever that source is reconfigured. When the counter reaches zero, the source reports locked, unless it is off. A select change is accepted only under three conditions: the target source is running, the target has finished locking, and the change is not a direct hop between two half-cycle multiplier codes.

The block does not switch clocks itself. It drives the committed select to a glitch-free multiplexer outside the block.

Top module: `clk_src_guard`

## Requirements
- R1: After synchronous reset the outputs are as follows. `sel_o`=0. Source 0 holds code `RST_CFG0` (default 12), range 0 and off bit 0, and it is locked. Source 1 holds code 0 and is unlocked. `err_o`=0 and `cause_o`=0.
- R2: A write with `wr_op`=0 targets source 0 and a write with `wr_op`=1 targets source 1. The code is in `wr_data[4:0]` and the range in `wr_data[6:5]`. Such a write is rejected with cause 1 when the target is the selected source. In that case the code and range stay unchanged.
- R3: A write of the source 0 off bit (`wr_op`=2, value in `wr_data[0]`) is rejected with cause 2 while source 0 is selected. The off bit stays unchanged.
- R4: An accepted code write, or an accepted off-bit write to source 0, reloads that source's lock counter. Its lock output is 0 for `LOCK_CYCLES` cycles and then reads 1. Exception: while a source is off, its lock output is always 0. A source is off when its code is 0, and source 0 is also off when its off bit is 1.
- R5: A select write (`wr_op`=3, target in `wr_data[0]`) to a running source that is not yet locked is rejected with cause 3.
- R6: A select write to a source that is off is rejected with cause 4. This check takes priority over causes 3 and 5.
- R7: Each code has a class. Code 0 is off. Codes 7, 9, 11 and 13 are half-cycle. All other codes, including 12, are full-cycle. A select change made while both sources hold half-cycle codes is rejected with cause 5.
- R8: A select change to a running, locked source is accepted without any wait. `sel_o` shows the new value one cycle after the write.
- R9: `sel_o` changes only on an accepted select write. A select write that names the current source is accepted and changes nothing.
- R10: Any rejection sets `err_o` and loads `cause_o` with the cause of that rejection. Both stay set through later accepted writes. A write with `wr_op`=4 and `wr_data[0]`=1 clears both. A write with `wr_op`=4 and `wr_data[0]`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe |
| wr_op | input | 3 | Write target: 0 code/range for source 0, 1 code/range for source 1, 2 off bit of source 0, 3 select, 4 error clear |
| wr_data | input | 7 | Write data: code in [4:0], range in [6:5], bit value in [0] |
| sel_o | output | 1 | Committed clock source select |
| cfg0_o | output | 5 | Source 0 multiplier code |
| cfg1_o | output | 5 | Source 1 multiplier code |
| rng0_o | output | 2 | Source 0 range |
| rng1_o | output | 2 | Source 1 range |
| off0_o | output | 1 | Source 0 off bit |
| lock0_o | output | 1 | Source 0 locked |
| lock1_o | output | 1 | Source 1 locked |
| err_o | output | 1 | Sticky rejection flag |
| cause_o | output | 3 | Cause of the latest rejection |

## Verification
The checker enforces several rules on every cycle:
- The selected source is never off and is always locked.
- `sel_o` moves only on a select write, and never between two half-cycle codes.
- A write aimed at the selected source leaves its fields unchanged and raises cause 1.
- A clear write drops the error flag.

Some behaviours only the bench's scenarios can show:
- The exact lock window length.
- The classification of every one of the 32 codes, which the bench sweeps on source 1.
- The priority among competing causes.
- The full off-and-back-on sequence for source 0.
- The legal path between two half-cycle codes through a full-cycle code.

// File: rtl/clk_guard_pkg.sv
package clk_guard_pkg;

  localparam int CODE_W = 5;
  localparam int RNG_W  = 2;

  typedef enum logic [2:0] {
    OP_CFG0 = 3'd0,
    OP_CFG1 = 3'd1,
    OP_OFF0 = 3'd2,
    OP_SEL  = 3'd3,
    OP_CLR  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    C_NONE     = 3'd0,
    C_SELECTED = 3'd1,
    C_OFF_BUSY = 3'd2,
    C_UNLOCKED = 3'd3,
    C_TGT_OFF  = 3'd4,
    C_HALF     = 3'd5
  } cause_e;

  typedef enum logic [1:0] {
    CL_OFF  = 2'd0,
    CL_FULL = 2'd1,
    CL_HALF = 2'd2
  } mclass_e;

  function automatic mclass_e classify(input logic [CODE_W-1:0] code,
                                       input logic [(1<<CODE_W)-1:0] half_mask);
    if (code == '0)           return CL_OFF;
    else if (half_mask[code]) return CL_HALF;
    else                      return CL_FULL;
  endfunction

endpackage

// File: rtl/pll_lock_track.sv
module pll_lock_track #(
  parameter int LOCK_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  input  logic is_off,
  output logic locked
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOCK_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (reload)      cnt_q <= LOAD_V;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign locked = (cnt_q == '0) && !is_off;
endmodule

// File: rtl/clk_guard_rules.sv
module clk_guard_rules
  import clk_guard_pkg::*;
(
  input  logic [2:0] op,
  input  logic       data_bit,
  input  logic       sel,
  input  logic [1:0] off,
  input  logic [1:0] lock,
  input  mclass_e    cls0,
  input  mclass_e    cls1,
  output logic       accept,
  output cause_e     cause
);
  logic tgt;
  assign tgt = data_bit;

  always_comb begin
    cause = C_NONE;
    case (op)
      OP_CFG0: if (sel == 1'b0) cause = C_SELECTED;
      OP_CFG1: if (sel == 1'b1) cause = C_SELECTED;
      OP_OFF0: if (sel == 1'b0) cause = C_OFF_BUSY;
      OP_SEL: begin
        if (tgt != sel) begin
          if (off[tgt])                             cause = C_TGT_OFF;
          else if (!lock[tgt])                      cause = C_UNLOCKED;
          else if (cls0 == CL_HALF && cls1 == CL_HALF) cause = C_HALF;
        end
      end
      default: cause = C_NONE;
    endcase
    accept = (cause == C_NONE);
  end
endmodule

// File: rtl/clk_src_guard.sv
module clk_src_guard
  import clk_guard_pkg::*;
#(
  parameter int LOCK_CYCLES = 64,
  parameter logic [31:0] HALF_MASK = 32'h0000_2A80,
  parameter logic [4:0]  RST_CFG0  = 5'd12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_valid,
  input  logic [2:0] wr_op,
  input  logic [6:0] wr_data,
  output logic       sel_o,
  output logic [4:0] cfg0_o,
  output logic [4:0] cfg1_o,
  output logic [1:0] rng0_o,
  output logic [1:0] rng1_o,
  output logic       off0_o,
  output logic       lock0_o,
  output logic       lock1_o,
  output logic       err_o,
  output logic [2:0] cause_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][CODE_W-1:0] cfg_q;
  logic [NSRC-1:0][RNG_W-1:0]  rng_q;
  logic                        sel_q, off0_q, err_q;
  cause_e                      cause_q;

  mclass_e         cls [NSRC];
  logic [NSRC-1:0] off_w, lock_w, reload_w;
  logic            accept;
  cause_e          cause_w;
  logic            do_write;

  assign do_write = wr_valid && (wr_op != OP_CLR);

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign cls[i] = classify(cfg_q[i], HALF_MASK);
      if (i == 0) begin : g_off0
        assign off_w[i]    = off0_q || (cls[i] == CL_OFF);
        assign reload_w[i] = do_write && accept &&
                             (wr_op == OP_CFG0 || wr_op == OP_OFF0);
      end else begin : g_offn
        assign off_w[i]    = (cls[i] == CL_OFF);
        assign reload_w[i] = do_write && accept && (wr_op == OP_CFG1);
      end
      pll_lock_track #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .reload (reload_w[i]),
        .is_off (off_w[i]),
        .locked (lock_w[i])
      );
    end
  endgenerate

  clk_guard_rules u_rules (
    .op       (wr_op),
    .data_bit (wr_data[0]),
    .sel      (sel_q),
    .off      (off_w),
    .lock     (lock_w),
    .cls0     (cls[0]),
    .cls1     (cls[1]),
    .accept   (accept),
    .cause    (cause_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      cfg_q   <= '{default: '0};
      cfg_q[0] <= RST_CFG0;
      rng_q   <= '{default: '0};
      off0_q  <= 1'b0;
      err_q   <= 1'b0;
      cause_q <= C_NONE;
    end else if (wr_valid) begin
      if (wr_op == OP_CLR) begin
        if (wr_data[0]) begin
          err_q   <= 1'b0;
          cause_q <= C_NONE;
        end
      end else if (!accept) begin
        err_q   <= 1'b1;
        cause_q <= cause_w;
      end else begin
        case (wr_op)
          OP_CFG0: begin
            cfg_q[0] <= wr_data[4:0];
            rng_q[0] <= wr_data[6:5];
          end
          OP_CFG1: begin
            cfg_q[1] <= wr_data[4:0];
            rng_q[1] <= wr_data[6:5];
          end
          OP_OFF0: off0_q <= wr_data[0];
          OP_SEL:  sel_q  <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  assign sel_o   = sel_q;
  assign cfg0_o  = cfg_q[0];
  assign cfg1_o  = cfg_q[1];
  assign rng0_o  = rng_q[0];
  assign rng1_o  = rng_q[1];
  assign off0_o  = off0_q;
  assign lock0_o = lock_w[0];
  assign lock1_o = lock_w[1];
  assign err_o   = err_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/clk_src_guard_chk.sv
module clk_src_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_valid,
  input logic [2:0] wr_op,
  input logic [6:0] wr_data,
  input logic       sel_o,
  input logic [4:0] cfg0_o,
  input logic [4:0] cfg1_o,
  input logic [1:0] rng0_o,
  input logic [1:0] rng1_o,
  input logic       off0_o,
  input logic       lock0_o,
  input logic       lock1_o,
  input logic       err_o,
  input logic [2:0] cause_o
);
  function automatic logic is_half(input logic [4:0] c);
    return (c == 5'd7) || (c == 5'd9) || (c == 5'd11) || (c == 5'd13);
  endfunction

  // R2: write to the selected source's fields is refused
  a_r2_sel_cfg_reject: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_op == 3'd0 && !sel_o) |=>
      (cfg0_o == $past(cfg0_o) && rng0_o == $past(rng0_o) && err_o && cause_o == 3'd1));

  a_r2_sel_cfg1_reject: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_op == 3'd1 && sel_o) |=>
      (cfg1_o == $past(cfg1_o) && rng1_o == $past(rng1_o) && err_o && cause_o == 3'd1));

  // R3: off bit frozen while source 0 selected
  a_r3_off_frozen: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_op == 3'd2 && !sel_o) |=> ($stable(off0_o) && cause_o == 3'd2));

  // R5, R6: the selected source is always running and locked
  a_r6_sel_not_off: assert property (@(posedge clk) disable iff (rst)
    sel_o ? (cfg1_o != 5'd0) : (cfg0_o != 5'd0 && !off0_o));

  a_r5_sel_locked: assert property (@(posedge clk) disable iff (rst)
    sel_o ? lock1_o : lock0_o);

  // R7: no select change between two half-cycle codes
  a_r7_no_half_hop: assert property (@(posedge clk) disable iff (rst)
    (sel_o != $past(sel_o)) |-> !(is_half(cfg0_o) && is_half(cfg1_o)));

  // R9: select moves only on a select write
  a_r9_sel_stable: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && wr_op == 3'd3) |=> $stable(sel_o));

  // R10: clear write drops the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_op == 3'd4 && wr_data[0]) |=> (!err_o && cause_o == 3'd0));

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_o && !(wr_valid && wr_op == 3'd4 && wr_data[0])) |=> err_o);
endmodule

bind clk_src_guard clk_src_guard_chk u_chk (.*);

// File: tb/clk_src_guard_tb_top.sv
`timescale 1ns/1ps
module clk_src_guard_tb_top;
  localparam int LC = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic [2:0] wr_op = '0;
  logic [6:0] wr_data = '0;
  logic       sel_o, off0_o, lock0_o, lock1_o, err_o;
  logic [4:0] cfg0_o, cfg1_o;
  logic [1:0] rng0_o, rng1_o;
  logic [2:0] cause_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  clk_src_guard #(.LOCK_CYCLES(LC)) dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_op(wr_op), .wr_data(wr_data),
    .sel_o(sel_o), .cfg0_o(cfg0_o), .cfg1_o(cfg1_o), .rng0_o(rng0_o), .rng1_o(rng1_o),
    .off0_o(off0_o), .lock0_o(lock0_o), .lock1_o(lock1_o), .err_o(err_o), .cause_o(cause_o)
  );

  function automatic bit half_c(input int c);
    return (c == 7) || (c == 9) || (c == 11) || (c == 13);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int op, input int data);
    wr_valid = 1'b1;
    wr_op    = 3'(op);
    wr_data  = 7'(data);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr();
    wr(4, 1);
  endtask

  task automatic expect_err(input string req, input int cause);
    chk(req, err_o, 1);
    chk(req, cause_o, cause);
    clr();
  endtask

  initial begin
    idle(2);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 sel", sel_o, 0);
    chk("R1 cfg0", cfg0_o, 12);
    chk("R1 cfg1", cfg1_o, 0);
    chk("R1 lock0", lock0_o, 1);
    chk("R1 lock1", lock1_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 cause", cause_o, 0);
    chk("R1 off0", off0_o, 0);

    // R6 select off source 1
    wr(3, 1);
    chk("R6 sel kept", sel_o, 0);
    expect_err("R6 cause", 4);
    chk("R10 cleared", err_o, 0);

    // R2 write to selected source 0
    wr(0, (2 << 5) | 9);
    chk("R2 cfg0 kept", cfg0_o, 12);
    chk("R2 rng0 kept", rng0_o, 0);
    expect_err("R2 cause", 1);

    // R3 off bit while source 0 selected
    wr(2, 1);
    chk("R3 off0 kept", off0_o, 0);
    expect_err("R3 cause", 2);

    // R4 R5 R6 R7 R8 R11-style sweep of all 32 codes on source 1
    for (int c = 0; c < 32; c++) begin
      wr(1, ((c & 3) << 5) | c);
      chk("R4 cfg1 written", cfg1_o, c);
      chk("R4 rng1 written", rng1_o, c & 3);
      chk("R4 lock1 low after write", lock1_o, 0);
      if (c != 0) begin
        wr(3, 1);
        chk("R5 sel kept", sel_o, 0);
        expect_err("R5 cause unlocked", 3);
      end
      idle(LC - 1 - ((c != 0) ? 2 : 0));
      chk("R4 lock1 before window end", lock1_o, 0);
      @(negedge clk);
      chk("R4 lock1 at window end", lock1_o, (c != 0) ? 1 : 0);
      wr(3, 1);
      if (c == 0) begin
        chk("R6 sel kept", sel_o, 0);
        expect_err("R6 cause off", 4);
      end else begin
        chk("R8 sel switched", sel_o, 1);
        chk("R8 no err", err_o, 0);
        wr(3, 0);
        chk("R8 sel back", sel_o, 0);
      end
    end

    // R9 same-value select is a no-op without error
    wr(3, 0);
    chk("R9 sel same", sel_o, 0);
    chk("R9 no err", err_o, 0);

    // R7 half-cycle hop ban and legal path through a full-cycle code
    wr(1, 12); idle(LC);
    wr(3, 1);
    chk("R8 sel to full", sel_o, 1);
    wr(0, 9); idle(LC);
    chk("R4 lock0 relocked", lock0_o, 1);
    wr(3, 0);
    chk("R7 half to full allowed", sel_o, 0);
    wr(1, 13); idle(LC);
    wr(3, 1);
    chk("R7 sel kept", sel_o, 0);
    chk("R7 half pair", half_c(cfg0_o) && half_c(cfg1_o), 1);
    expect_err("R7 cause", 5);
    wr(1, 12); idle(LC);
    wr(3, 1);
    chk("R7 legal path step", sel_o, 1);
    wr(0, 13); idle(LC);
    wr(3, 0);
    chk("R7 legal path end", sel_o, 0);
    chk("R7 cfg0", cfg0_o, 13);

    // R10 sticky across accepted writes, clear with bit0=0 ignored
    wr(1, 12);
    chk("R2 cfg1 accepted", cfg1_o, 12);
    wr(0, 12);
    chk("R10 set", err_o, 1);
    idle(LC);
    wr(3, 1);
    chk("R10 sel accepted", sel_o, 1);
    chk("R10 sticky err", err_o, 1);
    chk("R10 sticky cause", cause_o, 1);
    wr(4, 0);
    chk("R10 clear bit0=0 ignored", err_o, 1);
    wr(1, 12);
    chk("R10 cause latest", cause_o, 1);
    clr();
    chk("R10 cleared", err_o, 0);

    // R4 R6 source 0 off and back
    wr(0, 0);
    wr(2, 1);
    chk("R3 off0 set", off0_o, 1);
    idle(LC + 1);
    chk("R4 off reports unlocked", lock0_o, 0);
    wr(3, 0);
    chk("R6 sel kept", sel_o, 1);
    expect_err("R6 cause off0", 4);
    wr(2, 0);
    wr(0, 12);
    chk("R4 lock0 low", lock0_o, 0);
    wr(3, 0);
    chk("R5 sel kept", sel_o, 1);
    expect_err("R5 cause", 3);
    idle(LC - 2);
    wr(3, 0);
    chk("R8 sel after relock", sel_o, 0);
    chk("R8 no err", err_o, 0);

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule